// File: doc/BRIEF.md
# Threshold-Flagged Word FIFO

This block is a synchronous first-in first-out buffer of 32-bit words. It sits between a host that writes command data and a consumer that drains it. The depth is fixed when the block is built, and 64 and 128 words are the intended settings. The block reports its current fill level together with full and empty conditions. It also compares the fill level against two limits that software programs, one lower and one upper.

Four conditions raise latched status flags: full, empty, at or below the lower limit, and at or above the upper limit. Each flag has its own clear strobe and its own interrupt enable. One interrupt line combines the enabled flags. A write-side DMA request line lets a DMA engine keep the buffer topped up without software polling. The request is throttled by the block's own fill level.

Writes that arrive while the buffer is full are discarded, and so are reads that arrive while it is empty. Each of these records a sticky error bit, which only a reset clears. Read data comes from a register and is valid one clock after the read strobe.

Top module: `thresh_fifo`

## Requirements
- R1: A synchronous active-high reset empties the buffer. While reset is held and on the first cycle after it: fillLevel is 0, empty is 1, full is 0, flagStatus is 0, irq is 0, and both error bits are 0.
- R2: Words come out in the order they were written. The word for a read strobe accepted at a clock edge appears on rdData after that edge.
- R3: full is 1 exactly when fillLevel equals DEPTH. A write while full is dropped and leaves fillLevel unchanged. It also sets overflowErr, which stays 1 until reset.
- R4: A read while empty leaves rdData and fillLevel unchanged. It sets underflowErr, which stays 1 until reset.
- R5: A simultaneous accepted read and write, with the buffer neither full nor empty, leaves fillLevel unchanged.
- R6: fillLevel rises by one on each accepted lone write and falls by one on each accepted lone read. It never exceeds DEPTH.
- R7: flagStatus bit 2 (lower) is set at the clock edge after a cycle in which fillLevel <= lowLimit. It is not set when fillLevel is above lowLimit.
- R8: flagStatus bit 3 (upper) is set at the clock edge after a cycle in which fillLevel >= highLimit. Bits 0 (full) and 1 (empty) follow full and empty in the same way.
- R9: A flag stays set after its condition ends. A 1 on flagClr bit i clears flag i at that edge. The flag sets again at the following edge if its condition still holds.
- R10: irq is 1 exactly when some flagStatus bit is 1 and the same bit of irqEnable is 1.
- R11: dmaReq is 1 exactly when dmaEnable is 1 and full is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Word to write |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Registered read word |
| fillLevel | output | CW | Number of stored words |
| full | output | 1 | Buffer holds DEPTH words |
| empty | output | 1 | Buffer holds no words |
| lowLimit | input | CW | Lower fill limit |
| highLimit | input | CW | Upper fill limit |
| flagClr | input | 4 | Per-flag clear strobes (0 full, 1 empty, 2 lower, 3 upper) |
| irqEnable | input | 4 | Per-flag interrupt enables |
| flagStatus | output | 4 | Latched flags |
| irq | output | 1 | Combined interrupt |
| dmaEnable | input | 1 | Allows the DMA request |
| dmaReq | output | 1 | Write-side DMA request |
| overflowErr | output | 1 | Sticky dropped-write indicator |
| underflowErr | output | 1 | Sticky dropped-read indicator |

## Verification
Short bursts of distinct words, written and then drained, show ordering and the one-cycle read latency. Interleaved read-and-write cycles at a mid-level fill show that the count holds when both strobes are accepted. A fill to the full depth, followed by an extra write, separates the dropped write from an accepted one and exercises the DMA throttle at its edge. Fill levels driven across the two limits, with clears issued while a condition holds and after it has ended, separate the latched, sticky and re-arming behaviour of each flag. These stages also tell the lower-limit and upper-limit comparisons apart.

// File: rtl/thresh_fifo_pkg.sv
package thresh_fifo_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLAG_FULL  = 0;
  localparam int FLAG_EMPTY = 1;
  localparam int FLAG_LOW   = 2;
  localparam int FLAG_HIGH  = 3;

  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobeT;
endpackage

// File: rtl/thresh_fifo_ctrl.sv
module thresh_fifo_ctrl
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          dmaEnable,
  output fifoStrobeT    strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [CW-1:0] fillLevel,
  output logic          full,
  output logic          empty,
  output logic          dmaReq,
  output logic          overflowErr,
  output logic          underflowErr
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0] count;
  logic [AW-1:0] wrPtr, rdPtr;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  // a write is taken only with room, a read only with data
  always_comb begin
    strobe.push = wrEn & ~full;
    strobe.pop  = rdEn & ~empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count        <= '0;
      wrPtr        <= '0;
      rdPtr        <= '0;
      overflowErr  <= 1'b0;
      underflowErr <= 1'b0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wrEn && full)  overflowErr  <= 1'b1;
      if (rdEn && empty) underflowErr <= 1'b1;
    end
  end

  assign wrAddr    = wrPtr;
  assign rdAddr    = rdPtr;
  assign fillLevel = count;
  assign dmaReq    = dmaEnable & ~full;
endmodule

// File: rtl/thresh_fifo_dpath.sv
module thresh_fifo_dpath
  import thresh_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  fifoStrobeT        strobe,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdReg;

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  // read word is held when no read is accepted
  always_ff @(posedge clk) begin
    if (rst)             rdReg <= '0;
    else if (strobe.pop) rdReg <= mem[rdAddr];
  end

  assign rdData = rdReg;
endmodule

// File: rtl/thresh_fifo_flags.sv
module thresh_fifo_flags
  import thresh_fifo_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CW-1:0]        fillLevel,
  input  logic                 full,
  input  logic                 empty,
  input  logic [CW-1:0]        lowLimit,
  input  logic [CW-1:0]        highLimit,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic [NUM_FLAGS-1:0] irqEnable,
  output logic [NUM_FLAGS-1:0] flagStatus,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] cond;
  logic [NUM_FLAGS-1:0] flagReg;

  always_comb begin
    cond            = '0;
    cond[FLAG_FULL]  = full;
    cond[FLAG_EMPTY] = empty;
    cond[FLAG_LOW]   = (fillLevel <= lowLimit);
    cond[FLAG_HIGH]  = (fillLevel >= highLimit);
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flagReg[i] <= 1'b0;
      else if (flagClr[i]) flagReg[i] <= 1'b0;
      else if (cond[i])    flagReg[i] <= 1'b1;
    end
  end

  assign flagStatus = flagReg;
  assign irq        = |(flagReg & irqEnable);
endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo
  import thresh_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic [CW-1:0]     fillLevel,
  output logic              full,
  output logic              empty,
  input  logic [CW-1:0]     lowLimit,
  input  logic [CW-1:0]     highLimit,
  input  logic [3:0]        flagClr,
  input  logic [3:0]        irqEnable,
  output logic [3:0]        flagStatus,
  output logic              irq,
  input  logic              dmaEnable,
  output logic              dmaReq,
  output logic              overflowErr,
  output logic              underflowErr
);
  fifoStrobeT    strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  thresh_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .dmaEnable(dmaEnable),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr), .fillLevel(fillLevel),
    .full(full), .empty(empty), .dmaReq(dmaReq),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  thresh_fifo_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );

  thresh_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst(rst), .fillLevel(fillLevel), .full(full), .empty(empty),
    .lowLimit(lowLimit), .highLimit(highLimit), .flagClr(flagClr),
    .irqEnable(irqEnable), .flagStatus(flagStatus), .irq(irq)
  );
endmodule

// File: rtl/thresh_fifo_chk.sv
module thresh_fifo_chk #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic              rdEn,
  input logic [DATA_W-1:0] rdData,
  input logic [CW-1:0]     fillLevel,
  input logic              full,
  input logic              empty,
  input logic [3:0]        flagClr,
  input logic [3:0]        flagStatus,
  input logic              irq,
  input logic              dmaReq,
  input logic              overflowErr,
  input logic              underflowErr
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  p_full_not_empty_r3: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wrEn && !rdEn) |=> (full && overflowErr));

  p_sticky_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    overflowErr |=> overflowErr);

  p_underflow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rdEn && !wrEn) |=> ($stable(rdData) && underflowErr && empty));

  p_count_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wrEn && rdEn && !full && !empty) |=> $stable(fillLevel));

  p_level_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fillLevel <= DEPTH_C);

  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (|flagClr) |=> ((flagStatus & $past(flagClr)) == 4'b0000));

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (flagStatus == 4'b0000) |-> !irq);

  p_dma_throttle_r11: assert property (@(posedge clk) disable iff (rst)
    full |-> !dmaReq);
endmodule

bind thresh_fifo thresh_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .fillLevel(fillLevel), .full(full), .empty(empty), .flagClr(flagClr),
  .flagStatus(flagStatus), .irq(irq), .dmaReq(dmaReq),
  .overflowErr(overflowErr), .underflowErr(underflowErr)
);

// File: tb/thresh_fifo_tb.sv
`timescale 1ns/1ps
module thresh_fifo_tb;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 128;
  localparam int CW     = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0, dmaEnable = 1'b0;
  logic [DATA_W-1:0] wrData = '0;
  logic [CW-1:0] lowLimit = CW'(2), highLimit = CW'(4);
  logic [3:0] flagClr = '0, irqEnable = '0;
  logic [DATA_W-1:0] rdData;
  logic [CW-1:0] fillLevel;
  logic full, empty, irq, dmaReq, overflowErr, underflowErr;
  logic [3:0] flagStatus;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] model [$];

  always #10 clk = ~clk;

  thresh_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .fillLevel(fillLevel), .full(full), .empty(empty),
    .lowLimit(lowLimit), .highLimit(highLimit), .flagClr(flagClr),
    .irqEnable(irqEnable), .flagStatus(flagStatus), .irq(irq),
    .dmaEnable(dmaEnable), .dmaReq(dmaReq),
    .overflowErr(overflowErr), .underflowErr(underflowErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    wrEn = 1'b1; wrData = d;
    tick();
    wrEn = 1'b0;
    model.push_back(d);
  endtask

  task automatic pop_check(input string req);
    logic [DATA_W-1:0] e;
    e = model.pop_front();
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    chk(req, rdData, e);
  endtask

  task automatic t_reset();
    chk("R1 fillLevel", 32'(fillLevel), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 flagStatus", 32'(flagStatus), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 errors", {30'b0, overflowErr, underflowErr}, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(32'hA5A5_0000 + 32'(i * 7));
    chk("R6 level after writes", 32'(fillLevel), 5);
    pop_check("R2 first word");
    chk("R6 level after read", 32'(fillLevel), 4);
    for (int i = 0; i < 4; i++) pop_check("R2 burst order");
    chk("R6 level drained", 32'(fillLevel), 0);
  endtask

  task automatic t_underflow();
    logic [DATA_W-1:0] prev;
    prev = rdData;
    rdEn = 1'b1;
    tick();
    rdEn = 1'b0;
    chk("R4 rdData held", rdData, prev);
    chk("R4 level", 32'(fillLevel), 0);
    chk("R4 underflowErr", 32'(underflowErr), 1);
    tick();
    chk("R4 underflow sticky", 32'(underflowErr), 1);
  endtask

  task automatic t_simul();
    logic [DATA_W-1:0] e;
    for (int i = 0; i < 3; i++) push(32'h1000 + 32'(i));
    for (int i = 0; i < 4; i++) begin
      e = model.pop_front();
      model.push_back(32'h2000 + 32'(i));
      wrEn = 1'b1; rdEn = 1'b1; wrData = 32'h2000 + 32'(i);
      tick();
      chk("R5 level held", 32'(fillLevel), 3);
      chk("R2 data during mixed", rdData, e);
    end
    wrEn = 1'b0; rdEn = 1'b0;
    while (model.size() > 0) pop_check("R2 drain after mixed");
  endtask

  task automatic t_full();
    dmaEnable = 1'b1;
    for (int i = 0; i < DEPTH - 1; i++) push(32'hC000_0000 ^ 32'(i * 3));
    chk("R11 dmaReq below full", 32'(dmaReq), 1);
    chk("R3 not yet full", 32'(full), 0);
    push(32'hFEED_BEEF);
    chk("R3 full at depth", 32'(full), 1);
    chk("R11 dmaReq off at full", 32'(dmaReq), 0);
    wrEn = 1'b1; wrData = 32'hDEAD_DEAD;
    tick();
    wrEn = 1'b0;
    chk("R3 level unchanged", 32'(fillLevel), DEPTH);
    chk("R3 overflowErr", 32'(overflowErr), 1);
    while (model.size() > 0) pop_check("R3 dropped word absent");
    chk("R11 dmaReq after drain", 32'(dmaReq), 1);
    dmaEnable = 1'b0;
    #1;
    chk("R11 dmaReq disabled", 32'(dmaReq), 0);
  endtask

  task automatic t_limits();
    flagClr = 4'hF;
    tick();
    flagClr = 4'h0;
    chk("R9 cleared", 32'(flagStatus), 0);
    tick();
    chk("R9 rearm empty and lower", 32'(flagStatus), 32'b0110);
    for (int i = 0; i < 4; i++) push(32'h300 + 32'(i));
    tick();
    chk("R8 upper set at limit", 32'(flagStatus[3]), 1);
    flagClr = 4'hF;
    tick();
    flagClr = 4'h0;
    tick();
    chk("R7 lower stays clear above limit", 32'(flagStatus), 32'b1000);
    pop_check("R2 limit data");
    pop_check("R2 limit data");
    tick();
    chk("R7 lower set at limit", 32'(flagStatus[2]), 1);
    chk("R9 upper sticky", 32'(flagStatus), 32'b1100);
  endtask

  task automatic t_irq();
    irqEnable = 4'b0001;
    #1;
    chk("R10 irq masked", 32'(irq), 0);
    irqEnable = 4'b0100;
    #1;
    chk("R10 irq lower", 32'(irq), 1);
    irqEnable = 4'b0000;
    #1;
    chk("R10 irq none", 32'(irq), 0);
    while (model.size() > 0) pop_check("R2 final drain");
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_order();
    t_underflow();
    t_simul();
    t_full();
    t_limits();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule